// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Controller

This block holds two pending flags for each of up to four processors. One flag is an interprocessor interrupt (IPI) and the other is an interval-timer interrupt. Each flag drives an interrupt line to its processor. Software posts and retires IPIs, and acknowledges timer interrupts, by writing processor bitmasks through a small register port.

A combined control register carries three 4-bit processor masks in one word. One mask requests IPIs, one clears IPIs and one clears timer interrupts. Three dedicated registers do the same three jobs, one each, taking a plain processor mask in the low bits.

A periodic `tick` input raises the timer flag of every processor. Reading the combined register returns both pending vectors and the number of the processor that issues the read. Redundant IPI operations raise a one-cycle warning pulse. Writes that name nothing raise a one-cycle error pulse and change no state.

Top module: `ipi_tmr_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, every pending flag, `ipi_irq`, `tmr_irq`, `warn_pulse` and `err_pulse` read zero until the first write or tick.
- R2: A write to the combined register (`addr` 0) sets the IPI flag of every processor named in `wdata[15:12]`. The flag is visible on `ipi_irq` in the cycle after the write edge.
- R3: A write to the combined register clears the IPI flag of every processor named in `wdata[11:8]`. Requests are applied before clears, so a processor named in both fields ends with its flag clear. An `ipi_irq` bit only falls after a write.
- R4: A write to the combined register clears the timer flag of every processor named in `wdata[7:4]`.
- R5: A cycle with `tick` high sets the timer flag of every processor. When a timer clear and a tick fall in the same cycle, the tick wins and all timer flags end set.
- R6: `warn_pulse` is high for exactly the cycle after a write in which either of these occurs:
  - an IPI request names a processor whose flag was already set;
  - an IPI clear names a processor whose flag is not set after the request step.
  Timer clears and ticks never warn.
- R7: A combined-register write whose three mask fields are all zero, with `wdata[28]` also zero, raises `err_pulse` in the next cycle and changes no IPI flag. With `wdata[28]` set, such a write is accepted silently as a no-op.
- R8: The dedicated registers take a mask in `wdata[NCPU-1:0]`:
  - `addr` 1 clears IPIs;
  - `addr` 2 clears timer flags;
  - `addr` 3 requests IPIs.
  They follow the same warning rules as the combined register. An all-zero mask raises `err_pulse` and changes nothing.
- R9: Mask bits for processor numbers at or above `NCPU` are ignored. With `NCPU` = 4, a dedicated-register write with only `wdata[5:4]` set counts as an all-zero mask.
- R10: `rdata` depends on `addr` in the same cycle, and every bit not listed below reads zero:
  - `addr` 0 gives IPI flags in bits 11:8, timer flags in bits 7:4 and `req_cpu` in bits 1:0;
  - `addr` 1 gives the IPI flags in the low bits;
  - `addr` 2 gives the timer flags in the low bits;
  - `addr` 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for writes and reads |
| wdata | input | DW (32) | Write data |
| req_cpu | input | 2 | Number of the processor issuing the access |
| tick | input | 1 | Interval-timer tick, one cycle per period |
| rdata | output | DW (32) | Read data for `addr` |
| ipi_irq | output | NCPU (4) | IPI line per processor |
| tmr_irq | output | NCPU (4) | Timer interrupt line per processor |
| warn_pulse | output | 1 | Redundant IPI post or clear in the previous cycle |
| err_pulse | output | 1 | Empty or unsupported write in the previous cycle |

## Verification
Two pairs of functions can land in the same cycle. An IPI request and an IPI clear can target the same processor within one combined write. A timer clear can coincide with a tick. The bench drives both collisions in a single cycle each. The scoreboard model applies request-then-clear and clear-then-tick ordering bit by bit, and compares the resulting flags and the warning pulse one cycle later.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  // Register select values seen on addr
  typedef enum logic [1:0] {
    SEL_COMBINED = 2'd0,
    SEL_IPI_CLR  = 2'd1,
    SEL_TMR_CLR  = 2'd2,
    SEL_IPI_REQ  = 2'd3
  } reg_sel_e;

  // Field layout of the combined register
  localparam int FIELD_W      = 4;
  localparam int IPI_REQ_LSB  = 12;
  localparam int IPI_CLR_LSB  = 8;
  localparam int TMR_CLR_LSB  = 4;
  localparam int ACK_BIT      = 28;
  localparam int RD_IPI_LSB   = 8;
  localparam int RD_TMR_LSB   = 4;

  // Flags after the request step
  function automatic logic [FIELD_W-1:0] apply_req(
    input logic [FIELD_W-1:0] pend,
    input logic [FIELD_W-1:0] req
  );
    return pend | req;
  endfunction

  // Flags after the clear step
  function automatic logic [FIELD_W-1:0] apply_clr(
    input logic [FIELD_W-1:0] pend,
    input logic [FIELD_W-1:0] clr
  );
    return pend & ~clr;
  endfunction

  // A request that names a processor already pending
  function automatic logic redundant_req(
    input logic [FIELD_W-1:0] pend,
    input logic [FIELD_W-1:0] req
  );
    return |(pend & req);
  endfunction

  // A clear that names a processor with nothing pending
  function automatic logic stale_clr(
    input logic [FIELD_W-1:0] pend,
    input logic [FIELD_W-1:0] clr
  );
    return |(clr & ~pend);
  endfunction

endpackage

// File: rtl/ipt_wr_decode.sv
module ipt_wr_decode
  import ipt_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int DW   = 32
) (
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [NCPU-1:0] ipi_req,
  output logic [NCPU-1:0] ipi_clr,
  output logic [NCPU-1:0] tmr_clr,
  output logic            wr_err
);

  reg_sel_e        sel;
  logic [NCPU-1:0] f_req, f_iclr, f_tclr, f_low;
  logic            ack;
  logic            empty;

  assign sel    = reg_sel_e'(addr);
  assign f_req  = wdata[IPI_REQ_LSB +: NCPU];
  assign f_iclr = wdata[IPI_CLR_LSB +: NCPU];
  assign f_tclr = wdata[TMR_CLR_LSB +: NCPU];
  assign f_low  = wdata[NCPU-1:0];
  assign ack    = wdata[ACK_BIT];

  always_comb begin
    empty = 1'b0;
    if (wr_en) begin
      unique case (sel)
        SEL_COMBINED: empty = (f_req == '0) && (f_iclr == '0) &&
                              (f_tclr == '0) && !ack;
        default:      empty = (f_low == '0);
      endcase
    end
  end

  always_comb begin
    ipi_req = '0;
    ipi_clr = '0;
    tmr_clr = '0;
    if (wr_en && !empty) begin
      unique case (sel)
        SEL_COMBINED: begin
          ipi_req = f_req;
          ipi_clr = f_iclr;
          tmr_clr = f_tclr;
        end
        SEL_IPI_CLR: ipi_clr = f_low;
        SEL_TMR_CLR: tmr_clr = f_low;
        SEL_IPI_REQ: ipi_req = f_low;
        default: ;
      endcase
    end
  end

  assign wr_err = empty;

endmodule

// File: rtl/ipt_ipi_bank.sv
module ipt_ipi_bank
  import ipt_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] req,
  input  logic [NCPU-1:0] clr,
  output logic [NCPU-1:0] pend,
  output logic            warn
);

  logic [NCPU-1:0]    pend_q;
  logic [NCPU-1:0]    pend_d;
  logic [FIELD_W-1:0] pend_w, req_w, clr_w, mid_w, fin_w;

  assign pend_w = FIELD_W'(pend_q);
  assign req_w  = FIELD_W'(req);
  assign clr_w  = FIELD_W'(clr);
  assign mid_w  = apply_req(pend_w, req_w);
  assign fin_w  = apply_clr(mid_w, clr_w);

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    assign pend_d[i] = fin_w[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign warn = redundant_req(pend_w, req_w) | stale_clr(mid_w, clr_w);
  assign pend = pend_q;

endmodule

// File: rtl/ipt_tmr_bank.sv
module ipt_tmr_bank #(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NCPU-1:0] clr,
  output logic [NCPU-1:0] pend
);

  logic [NCPU-1:0] pend_q;
  logic [NCPU-1:0] pend_d;

  // A tick in the same cycle as a clear leaves the flag set
  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    assign pend_d[i] = tick | (pend_q[i] & ~clr[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

endmodule

// File: rtl/ipi_tmr_ctrl.sv
module ipi_tmr_ctrl
  import ipt_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  input  logic [1:0]      req_cpu,
  input  logic            tick,
  output logic [DW-1:0]   rdata,
  output logic [NCPU-1:0] ipi_irq,
  output logic [NCPU-1:0] tmr_irq,
  output logic            warn_pulse,
  output logic            err_pulse
);

  // Decoded events, named for the checker
  logic [NCPU-1:0] ev_ipi_req;
  logic [NCPU-1:0] ev_ipi_clr;
  logic [NCPU-1:0] ev_tmr_clr;
  logic            ev_err;
  logic            ev_warn;
  logic [NCPU-1:0] ipi_pend;
  logic [NCPU-1:0] tmr_pend;
  logic            warn_q, err_q;
  reg_sel_e        rsel;

  ipt_wr_decode #(.NCPU(NCPU), .DW(DW)) u_dec (
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .ipi_req (ev_ipi_req),
    .ipi_clr (ev_ipi_clr),
    .tmr_clr (ev_tmr_clr),
    .wr_err  (ev_err)
  );

  ipt_ipi_bank #(.NCPU(NCPU)) u_ipi (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (ev_ipi_req),
    .clr   (ev_ipi_clr),
    .pend  (ipi_pend),
    .warn  (ev_warn)
  );

  ipt_tmr_bank #(.NCPU(NCPU)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .clr   (ev_tmr_clr),
    .pend  (tmr_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      warn_q <= ev_warn;
      err_q  <= ev_err;
    end
  end

  assign rsel = reg_sel_e'(addr);

  always_comb begin
    rdata = '0;
    unique case (rsel)
      SEL_COMBINED: begin
        rdata[RD_IPI_LSB +: NCPU] = ipi_pend;
        rdata[RD_TMR_LSB +: NCPU] = tmr_pend;
        rdata[1:0]                = req_cpu;
      end
      SEL_IPI_CLR: rdata[NCPU-1:0] = ipi_pend;
      SEL_TMR_CLR: rdata[NCPU-1:0] = tmr_pend;
      default:     rdata = '0;
    endcase
  end

  assign ipi_irq    = ipi_pend;
  assign tmr_irq    = tmr_pend;
  assign warn_pulse = warn_q;
  assign err_pulse  = err_q;

endmodule

// File: rtl/ipt_checker.sv
module ipt_checker #(
  parameter int NCPU = 4,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [1:0]      addr,
  input logic [DW-1:0]   wdata,
  input logic            tick,
  input logic [NCPU-1:0] ipi_irq,
  input logic [NCPU-1:0] tmr_irq,
  input logic            warn_pulse,
  input logic            err_pulse
);

  // R2, R8: a dedicated request sets every named line
  a_r2_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wdata[NCPU-1:0] != '0)
      |=> ((ipi_irq & $past(wdata[NCPU-1:0])) == $past(wdata[NCPU-1:0])));

  // R5: every timer line is high after a tick
  a_r5_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (&tmr_irq));

  // R7: an empty combined write raises an error
  a_r7_empty_err: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata[15:4] == '0 && !wdata[28]) |=> err_pulse);

  // R7, R8: a rejected write leaves the IPI lines alone
  a_r8_err_keeps_ipi: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (ipi_irq == $past(ipi_irq)));

  // R3: an IPI line only falls after a write
  a_r3_fall_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(ipi_irq) & ~ipi_irq)) |-> $past(wr_en));

  // R6: warnings only follow writes
  a_r6_warn_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    warn_pulse |-> $past(wr_en));

endmodule

bind ipi_tmr_ctrl ipt_checker #(.NCPU(NCPU), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .tick       (tick),
  .ipi_irq    (ipi_irq),
  .tmr_irq    (tmr_irq),
  .warn_pulse (warn_pulse),
  .err_pulse  (err_pulse)
);

// File: tb/test_ipi_tmr_ctrl.sv
module test_ipi_tmr_ctrl;

  localparam int NCPU = 4;
  localparam int DW   = 32;

  typedef struct {
    logic [3:0] ipi;
    logic [3:0] tmr;
    logic       warn;
    logic       err;
    string      tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [1:0]      addr = '0;
  logic [DW-1:0]   wdata = '0;
  logic [1:0]      req_cpu = '0;
  logic            tick = 1'b0;
  logic [DW-1:0]   rdata;
  logic [NCPU-1:0] ipi_irq, tmr_irq;
  logic            warn_pulse, err_pulse;

  int   checks = 0;
  int   errors = 0;
  exp_t q[$];
  logic [3:0] m_ipi = '0;
  logic [3:0] m_tmr = '0;
  bit   done = 0;

  always #2 clk = ~clk;

  ipi_tmr_ctrl #(.NCPU(NCPU), .DW(DW)) i_ipi_tmr_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .req_cpu(req_cpu), .tick(tick), .rdata(rdata), .ipi_irq(ipi_irq),
    .tmr_irq(tmr_irq), .warn_pulse(warn_pulse), .err_pulse(err_pulse)
  );

  // Monitor: pops one expected item per cycle and compares
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (ipi_irq !== e.ipi || tmr_irq !== e.tmr ||
            warn_pulse !== e.warn || err_pulse !== e.err) begin
          errors++;
          $display("FAIL %s: ipi=%b tmr=%b warn=%b err=%b expected ipi=%b tmr=%b warn=%b err=%b",
                   e.tag, ipi_irq, tmr_irq, warn_pulse, err_pulse,
                   e.ipi, e.tmr, e.warn, e.err);
        end
      end
    end
  end

  // Driver: one cycle of stimulus plus the expected result
  task automatic cyc(input logic w, input logic [1:0] a, input logic [31:0] d,
                     input logic t, input string tag);
    exp_t e;
    logic [3:0] rq, cl, tc;
    logic er, wn;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; tick = t;
    rq = 4'h0; cl = 4'h0; tc = 4'h0; er = 1'b0; wn = 1'b0;
    if (w) begin
      if (a == 2'd0) begin
        rq = d[15:12]; cl = d[11:8]; tc = d[7:4];
        er = (rq == 4'h0) && (cl == 4'h0) && (tc == 4'h0) && !d[28];
      end else begin
        er = (d[3:0] == 4'h0);
        if (a == 2'd1) cl = d[3:0];
        if (a == 2'd2) tc = d[3:0];
        if (a == 2'd3) rq = d[3:0];
      end
      if (er) begin rq = 4'h0; cl = 4'h0; tc = 4'h0; end
    end
    for (int i = 0; i < 4; i++)
      if (rq[i]) begin
        if (m_ipi[i]) wn = 1'b1;
        else          m_ipi[i] = 1'b1;
      end
    for (int i = 0; i < 4; i++)
      if (cl[i]) begin
        if (!m_ipi[i]) wn = 1'b1;
        else           m_ipi[i] = 1'b0;
      end
    for (int i = 0; i < 4; i++) begin
      if (tc[i]) m_tmr[i] = 1'b0;
      if (t)     m_tmr[i] = 1'b1;
    end
    e.ipi = m_ipi; e.tmr = m_tmr; e.warn = wn; e.err = er; e.tag = tag;
    @(posedge clk);
    #1;
    q.push_back(e);
  endtask

  task automatic rd(input logic [1:0] a, input logic [1:0] cpu, input string tag);
    logic [31:0] ex;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; addr = a; req_cpu = cpu;
    ex = '0;
    if (a == 2'd0) ex = {20'h0, m_ipi, m_tmr, 2'b00, cpu};
    if (a == 2'd1) ex = {28'h0, m_ipi};
    if (a == 2'd2) ex = {28'h0, m_tmr};
    #1;
    checks++;
    if (rdata !== ex) begin
      errors++;
      $display("FAIL %s: rdata=%h expected %h", tag, rdata, ex);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (ipi_irq !== 4'h0 || tmr_irq !== 4'h0 || warn_pulse !== 1'b0 || err_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: ipi=%b tmr=%b warn=%b err=%b expected all zero",
               ipi_irq, tmr_irq, warn_pulse, err_pulse);
    end
    rst_n = 1'b1;
    cyc(0, 2'd0, 32'h0, 0, "R1 idle after reset");
    rd(2'd0, 2'd0, "R1 R10 combined read after reset");
    cyc(1, 2'd0, 32'h0000_5000, 0, "R2 request cpu0 cpu2");
    cyc(1, 2'd0, 32'h0000_3000, 0, "R6 request cpu0 cpu1 with cpu0 pending");
    cyc(1, 2'd0, 32'h0000_0200, 0, "R3 clear cpu1");
    cyc(1, 2'd0, 32'h0000_8800, 0, "R3 request and clear cpu3 together");
    cyc(1, 2'd0, 32'h0000_0200, 0, "R6 clear non-pending cpu1");
    cyc(1, 2'd0, 32'h0000_0000, 1, "R5 tick");
    cyc(1, 2'd0, 32'h0000_0030, 0, "R4 clear timer cpu0 cpu1");
    rd(2'd2, 2'd0, "R10 timer read");
    cyc(1, 2'd0, 32'h0000_00F0, 1, "R5 tick wins over timer clear");
    cyc(1, 2'd0, 32'h0000_0000, 0, "R7 empty combined write");
    cyc(1, 2'd0, 32'h1000_0000, 0, "R7 acknowledge bit alone");
    cyc(1, 2'd3, 32'h0000_0002, 0, "R8 dedicated request cpu1");
    cyc(1, 2'd1, 32'h0000_0001, 0, "R8 dedicated clear cpu0");
    cyc(1, 2'd2, 32'h0000_0005, 0, "R8 dedicated timer clear");
    cyc(1, 2'd1, 32'h0000_0000, 0, "R8 dedicated zero mask");
    cyc(1, 2'd3, 32'h0000_0030, 0, "R9 bits above NCPU only");
    cyc(1, 2'd3, 32'h0000_0012, 0, "R9 R6 high bit ignored, cpu1 redundant");
    rd(2'd0, 2'd2, "R10 combined read cpu2");
    rd(2'd1, 2'd1, "R10 ipi read");
    rd(2'd3, 2'd3, "R10 request register reads zero");
    cyc(1, 2'd0, 32'h0000_F0F0, 0, "R2 R4 request all, clear all timers");
    cyc(0, 2'd0, 32'h0, 0, "R2 idle hold");
    rd(2'd0, 2'd1, "R10 combined read cpu1");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule